// File: doc/BRIEF.md
# Signed multiply-add accumulate datapath

A pipelined arithmetic slice. It multiplies a 25-bit signed operand by an 18-bit signed operand, then adds that product to a third 48-bit operand, to its own running total, or to a neighbour's partial result arriving on a cascade input. That cascade input is shifted right arithmetically by 17 bits. A neighbouring slice can therefore pass up the upper part of its partial product, right-justified, and a chain of slices forms a product wider than one multiplier.

A bypass operation ignores the multiplier. It sums three 48-bit signed values:
- the sign-extended concatenation of the two multiplier operands, with the 25-bit operand high,
- the third operand,
- the accumulator.

A parameter removes the multiplier logic entirely. In that case the product term is zero.

Four pipeline registers are each enabled by a parameter:
- the input register for the two multiplier operands,
- the third-operand register,
- the product register,
- the output/accumulator register.

Each register has its own synchronous reset and clock enable. The registered result is also driven on a cascade output for the next slice.

Top module: `mac_slice`

## Requirements
- R1: Each register has a synchronous, active-high reset that clears it to zero and takes priority over its clock enable; after reset the result is zero.
- R2: Operation code 2'b00 loads the result with the sign-extended 43-bit product of the signed operands plus the third operand.
- R3: Operation code 2'b01 loads the result with the product plus the current result. The total wraps modulo 2^48: 64 additions of 2^41 from zero give 48'h800000000000, and 128 give zero.
- R4: Operation code 2'b10 ignores the product. It loads the result with the sign-extended 43-bit concatenation {A,B} (A in the upper 25 bits) plus the third operand plus the current result.
- R5: Operation code 2'b11 loads the result with the product plus the cascade input shifted right arithmetically by 17 bits.
- R6: With all registers enabled (the default), the timing is as follows:
  - A and B reach the result through the product in 3 clock edges, and through the bypass in 2 edges.
  - The third operand reaches the result in 2 edges.
  - The operation code and the cascade input are taken at the edge that loads the result.
- R7: A register whose clock enable is low and whose reset is low keeps its value.
- R8: The cascade output always equals the result.
- R9: With the multiplier disabled by parameter, the product term is zero in every operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ab | input | 1 | Reset of the A/B input register |
| rst_c | input | 1 | Reset of the third-operand register |
| rst_m | input | 1 | Reset of the product register |
| rst_p | input | 1 | Reset of the result register |
| ce_ab | input | 1 | Clock enable of the A/B input register |
| ce_c | input | 1 | Clock enable of the third-operand register |
| ce_m | input | 1 | Clock enable of the product register |
| ce_p | input | 1 | Clock enable of the result register |
| a | input | 25 | Signed multiplier operand (upper part of the bypass value) |
| b | input | 18 | Signed multiplier operand (lower part of the bypass value) |
| c | input | 48 | Signed third operand |
| pcin | input | 48 | Cascade input from the previous slice |
| op | input | 2 | Operation code |
| p | output | 48 | Result / accumulator |
| pcout | output | 48 | Cascade output to the next slice |

## Verification
Two behaviours are hard to reach from the ports.

The first is the modulo-2^48 wrap of the accumulator. Only the largest product, (-2^24)·(-2^17) = 2^41, gets there in a bounded run. The stimulus holds that product while the result register is under reset, so the product register fills. It then releases the reset and counts exactly 64 and 128 accumulating edges.

The second is the shifted cascade term. It is only seen on its own once the product pipeline has drained to zero. The bench first clears A and B for two edges and then applies the most negative and the most positive cascade values. A behavioural model then compares every cycle during a long mixed run with scattered enables and resets, covering both a multiplying slice and one with the multiplier removed.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [1:0] {
    OP_MC   = 2'b00,
    OP_MACC = 2'b01,
    OP_SUM3 = 2'b10,
    OP_MCAS = 2'b11
  } mac_op_e;

  localparam int unsigned DEF_A_W   = 25;
  localparam int unsigned DEF_B_W   = 18;
  localparam int unsigned DEF_P_W   = 48;
  localparam int unsigned DEF_SHIFT = 17;

endpackage

// File: rtl/mac_pipe_reg.sv
module mac_pipe_reg #(
  parameter int unsigned W  = 8,
  parameter bit          EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  if (EN) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)     q <= '0;
      else if (ce) q <= d;
    end
  end else begin : g_wire
    assign q = d;
  end

endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int unsigned A_W      = mac_pkg::DEF_A_W,
  parameter int unsigned B_W      = mac_pkg::DEF_B_W,
  parameter int unsigned P_W      = mac_pkg::DEF_P_W,
  parameter bit          USE_MULT = 1'b1,
  parameter bit          MREG     = 1'b1
) (
  input  logic           clk,
  input  logic           rst_m,
  input  logic           ce_m,
  input  logic [A_W-1:0] a_in,
  input  logic [B_W-1:0] b_in,
  output logic [P_W-1:0] prod
);

  localparam int unsigned M_W   = A_W + B_W;
  localparam int unsigned EXT_W = P_W - M_W;

  function automatic logic [P_W-1:0] f_mul_ext(input logic [A_W-1:0] x,
                                               input logic [B_W-1:0] y);
    logic signed [M_W-1:0] full;
    full = $signed(x) * $signed(y);
    return {{EXT_W{full[M_W-1]}}, full};
  endfunction

  if (USE_MULT) begin : g_mul
    logic [P_W-1:0] prod_d;
    assign prod_d = f_mul_ext(a_in, b_in);
    mac_pipe_reg #(.W(P_W), .EN(MREG)) u_mreg (
      .clk(clk), .rst(rst_m), .ce(ce_m), .d(prod_d), .q(prod)
    );
  end else begin : g_nomul
    assign prod = '0;
  end

endmodule

// File: rtl/mac_postadd.sv
module mac_postadd #(
  parameter int unsigned A_W   = mac_pkg::DEF_A_W,
  parameter int unsigned B_W   = mac_pkg::DEF_B_W,
  parameter int unsigned P_W   = mac_pkg::DEF_P_W,
  parameter int unsigned SHIFT = mac_pkg::DEF_SHIFT
) (
  input  mac_pkg::mac_op_e op,
  input  logic [P_W-1:0]   prod,
  input  logic [A_W-1:0]   a_q,
  input  logic [B_W-1:0]   b_q,
  input  logic [P_W-1:0]   c_q,
  input  logic [P_W-1:0]   pcin,
  input  logic [P_W-1:0]   acc,
  output logic [P_W-1:0]   sum,
  output logic             fb_used,
  output logic             cas_used
);
  import mac_pkg::*;

  localparam int unsigned CAT_W = A_W + B_W;
  localparam int unsigned EXT_W = P_W - CAT_W;

  function automatic logic [P_W-1:0] f_cat_ext(input logic [A_W-1:0] x,
                                               input logic [B_W-1:0] y);
    return {{EXT_W{x[A_W-1]}}, x, y};
  endfunction

  function automatic logic [P_W-1:0] f_cas_shift(input logic [P_W-1:0] v);
    logic signed [P_W-1:0] s;
    s = v;
    return P_W'(s >>> SHIFT);
  endfunction

  logic [P_W-1:0] x_term, y_term, z_term;

  always_comb begin
    x_term   = prod;
    y_term   = c_q;
    z_term   = '0;
    fb_used  = 1'b0;
    cas_used = 1'b0;
    unique case (op)
      OP_MC: ;
      OP_MACC: begin
        y_term  = acc;
        fb_used = 1'b1;
      end
      OP_SUM3: begin
        x_term  = f_cat_ext(a_q, b_q);
        z_term  = acc;
        fb_used = 1'b1;
      end
      OP_MCAS: begin
        y_term   = f_cas_shift(pcin);
        cas_used = 1'b1;
      end
      default: ;
    endcase
  end

  assign sum = x_term + y_term + z_term;

endmodule

// File: rtl/mac_slice.sv
module mac_slice #(
  parameter int unsigned A_W       = mac_pkg::DEF_A_W,
  parameter int unsigned B_W       = mac_pkg::DEF_B_W,
  parameter int unsigned P_W       = mac_pkg::DEF_P_W,
  parameter int unsigned CAS_SHIFT = mac_pkg::DEF_SHIFT,
  parameter bit          USE_MULT  = 1'b1,
  parameter bit          ABREG     = 1'b1,
  parameter bit          CREG      = 1'b1,
  parameter bit          MREG      = 1'b1,
  parameter bit          PREG      = 1'b1
) (
  input  logic           clk,
  input  logic           rst_ab,
  input  logic           rst_c,
  input  logic           rst_m,
  input  logic           rst_p,
  input  logic           ce_ab,
  input  logic           ce_c,
  input  logic           ce_m,
  input  logic           ce_p,
  input  logic [A_W-1:0] a,
  input  logic [B_W-1:0] b,
  input  logic [P_W-1:0] c,
  input  logic [P_W-1:0] pcin,
  input  logic [1:0]     op,
  output logic [P_W-1:0] p,
  output logic [P_W-1:0] pcout
);

  logic [A_W-1:0] a_term;
  logic [B_W-1:0] b_term;
  logic [P_W-1:0] c_term;
  logic [P_W-1:0] prod_term;
  logic [P_W-1:0] acc_fb;
  logic [P_W-1:0] sum_next;
  logic           fb_used;
  logic           cas_used;

  mac_pipe_reg #(.W(A_W), .EN(ABREG)) u_areg (
    .clk(clk), .rst(rst_ab), .ce(ce_ab), .d(a), .q(a_term)
  );
  mac_pipe_reg #(.W(B_W), .EN(ABREG)) u_breg (
    .clk(clk), .rst(rst_ab), .ce(ce_ab), .d(b), .q(b_term)
  );
  mac_pipe_reg #(.W(P_W), .EN(CREG)) u_creg (
    .clk(clk), .rst(rst_c), .ce(ce_c), .d(c), .q(c_term)
  );

  mac_mult #(
    .A_W(A_W), .B_W(B_W), .P_W(P_W), .USE_MULT(USE_MULT), .MREG(MREG)
  ) u_mult (
    .clk(clk), .rst_m(rst_m), .ce_m(ce_m),
    .a_in(a_term), .b_in(b_term), .prod(prod_term)
  );

  mac_postadd #(
    .A_W(A_W), .B_W(B_W), .P_W(P_W), .SHIFT(CAS_SHIFT)
  ) u_add (
    .op(mac_pkg::mac_op_e'(op)), .prod(prod_term),
    .a_q(a_term), .b_q(b_term), .c_q(c_term),
    .pcin(pcin), .acc(acc_fb), .sum(sum_next),
    .fb_used(fb_used), .cas_used(cas_used)
  );

  mac_pipe_reg #(.W(P_W), .EN(PREG)) u_preg (
    .clk(clk), .rst(rst_p), .ce(ce_p), .d(sum_next), .q(p)
  );

  if (PREG) begin : g_fb
    assign acc_fb = p;
  end else begin : g_nofb
    assign acc_fb = '0;
  end

  assign pcout = p;

endmodule

// File: rtl/mac_slice_chk.sv
module mac_slice_chk #(
  parameter int unsigned P_W       = 48,
  parameter int unsigned CAS_SHIFT = 17,
  parameter bit          PREG      = 1'b1
) (
  input logic           clk,
  input logic           rst_p,
  input logic           ce_p,
  input logic [1:0]     op,
  input logic [P_W-1:0] p,
  input logic [P_W-1:0] pcout,
  input logic [P_W-1:0] pcin,
  input logic [P_W-1:0] prod_term,
  input logic [P_W-1:0] c_term,
  input logic           fb_used,
  input logic           cas_used
);

  // R8
  pcout_mirror_chk: assert property (@(posedge clk) disable iff (rst_p)
    pcout == p);

  if (PREG) begin : g_p
    // R1
    rst_clear_chk: assert property (@(posedge clk) disable iff (rst_p)
      $fell(rst_p) |-> p == '0);

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst_p)
      !ce_p |=> $stable(p));

    // R3
    acc_zero_prod_chk: assert property (@(posedge clk) disable iff (rst_p)
      ce_p && fb_used && op == 2'b01 && prod_term == '0 |=> p == $past(p));

    // R5
    cas_shift_chk: assert property (@(posedge clk) disable iff (rst_p)
      ce_p && cas_used && prod_term == '0
      |=> $signed(p) == ($signed($past(pcin)) >>> CAS_SHIFT));

    // R2
    mc_sum_chk: assert property (@(posedge clk) disable iff (rst_p)
      ce_p && op == 2'b00 |=> p == $past(prod_term) + $past(c_term));
  end

endmodule

bind mac_slice mac_slice_chk #(
  .P_W(P_W), .CAS_SHIFT(CAS_SHIFT), .PREG(PREG)
) u_chk (
  .clk(clk), .rst_p(rst_p), .ce_p(ce_p), .op(op), .p(p), .pcout(pcout),
  .pcin(pcin), .prod_term(prod_term), .c_term(c_term),
  .fb_used(fb_used), .cas_used(cas_used)
);

// File: tb/mac_slice_tb.sv
module mac_slice_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int LIMIT = 200000;

  logic        clk = 1'b0;
  logic        rst_ab, rst_c, rst_m, rst_p;
  logic        ce_ab, ce_c, ce_m, ce_p;
  logic [24:0] a;
  logic [17:0] b;
  logic [47:0] c, pcin;
  logic [1:0]  op;
  logic [47:0] p, pcout, p0, pcout0;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit cmp_en = 1'b0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  mac_slice u_dut (
    .clk(clk), .rst_ab(rst_ab), .rst_c(rst_c), .rst_m(rst_m), .rst_p(rst_p),
    .ce_ab(ce_ab), .ce_c(ce_c), .ce_m(ce_m), .ce_p(ce_p),
    .a(a), .b(b), .c(c), .pcin(pcin), .op(op), .p(p), .pcout(pcout)
  );

  mac_slice #(.USE_MULT(1'b0)) u_nomul (
    .clk(clk), .rst_ab(rst_ab), .rst_c(rst_c), .rst_m(rst_m), .rst_p(rst_p),
    .ce_ab(ce_ab), .ce_c(ce_c), .ce_m(ce_m), .ce_p(ce_p),
    .a(a), .b(b), .c(c), .pcin(pcin), .op(op), .p(p0), .pcout(pcout0)
  );

  function automatic longint sx(longint v, int w);
    return (v <<< (64 - w)) >>> (64 - w);
  endfunction

  // reference model state
  longint ma, mb, mc, mm, mp, mp0;
  logic [1:0] last_op;
  bit last_rst, last_hold;

  function automatic longint nxt(logic [1:0] o, longint prod, longint acc);
    longint cat;
    cat = ma * 262144 + (mb & 64'h3FFFF);
    case (o)
      2'b00:   return sx(prod + mc, 48);
      2'b01:   return sx(prod + acc, 48);
      2'b10:   return sx(cat + mc + acc, 48);
      default: return sx(prod + (sx(longint'(pcin), 48) >>> 17), 48);
    endcase
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_ab) begin ma <= 0; mb <= 0; end
    else if (ce_ab) begin ma <= sx(longint'(a), 25); mb <= sx(longint'(b), 18); end
    if (rst_c) mc <= 0; else if (ce_c) mc <= sx(longint'(c), 48);
    if (rst_m) mm <= 0; else if (ce_m) mm <= ma * mb;
    if (rst_p) begin mp <= 0; mp0 <= 0; end
    else if (ce_p) begin mp <= nxt(op, mm, mp); mp0 <= nxt(op, 0, mp0); end
    last_op   <= op;
    last_rst  <= rst_p;
    last_hold <= !ce_p;
  end

  task automatic check(bit ok, string req, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string op_tag(logic [1:0] o);
    case (o)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (cmp_en && !done) begin
      string t;
      t = last_rst ? "R1" : (last_hold ? "R7" : op_tag(last_op));
      check(p === mp[47:0], {t, " R6 model"}, p, mp[47:0]);
      check(p0 === mp0[47:0], {"R9 ", t, " no-multiplier model"}, p0, mp0[47:0]);
      check(pcout === p, "R8 cascade out", pcout, p);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    if (cyc > LIMIT && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, LIMIT);
      summary();
      $finish;
    end
  end

  initial begin
    {rst_ab, rst_c, rst_m, rst_p} = 4'hF;
    {ce_ab, ce_c, ce_m, ce_p} = 4'hF;
    a = '0; b = '0; c = '0; pcin = '0; op = 2'b00;
    tick(3);
    {rst_ab, rst_c, rst_m, rst_p} = 4'h0;
    cmp_en = 1'b1;
    check(p === 48'h0, "R1 reset value", p, 48'h0);

    // R6 latency: a single product pulse
    tick(2);
    a = 25'd3; b = 18'd5;
    tick(1); check(p === 48'd0, "R6 edge1", p, 48'd0); a = '0; b = '0;
    tick(1); check(p === 48'd0, "R6 edge2", p, 48'd0);
    tick(1); check(p === 48'd15, "R6 edge3", p, 48'd15);
    tick(1); check(p === 48'd0, "R6 edge4", p, 48'd0);

    // R2 most negative operands
    a = 25'h1000000; b = 18'h20000; c = '0; op = 2'b00;
    tick(3); check(p === 48'h020000000000, "R2 corner product", p, 48'h020000000000);

    // R5 cascade shift with drained product
    a = '0; b = '0; tick(2);
    op = 2'b11; pcin = 48'h800000000000;
    tick(1); check(p === 48'hFFFFC0000000, "R5 negative cascade", p, 48'hFFFFC0000000);
    pcin = 48'h7FFFFFFFFFFF;
    tick(1); check(p === 48'h00003FFFFFFF, "R5 positive cascade", p, 48'h00003FFFFFFF);
    pcin = '0;

    // R4 bypass, three-operand sum
    rst_p = 1'b1; op = 2'b00; a = 25'h1FFFFFF; b = 18'h3FFFF; c = 48'd5;
    tick(1); rst_p = 1'b0; op = 2'b10;
    tick(1); check(p === 48'd4, "R4 bypass first", p, 48'd4);
    tick(1); check(p === 48'd8, "R4 bypass accumulate", p, 48'd8);

    // R3 wrap
    rst_p = 1'b1; a = 25'h1000000; b = 18'h20000; c = '0; op = 2'b01;
    tick(2); rst_p = 1'b0;
    tick(64); check(p === 48'h800000000000, "R3 wrap 64", p, 48'h800000000000);
    tick(64); check(p === 48'h0, "R3 wrap 128", p, 48'h0);

    // R1 reset priority over enable, R7 hold
    tick(3); check(p === 48'h060000000000, "R3 three adds", p, 48'h060000000000);
    rst_p = 1'b1; ce_p = 1'b1;
    tick(1); check(p === 48'h0, "R1 reset wins", p, 48'h0);
    rst_p = 1'b0;
    tick(2); check(p === 48'h040000000000, "R3 two adds", p, 48'h040000000000);
    ce_p = 1'b0;
    tick(5); check(p === 48'h040000000000, "R7 hold", p, 48'h040000000000);
    ce_p = 1'b1;

    // mixed run
    for (int i = 0; i < 1500; i++) begin
      int sel;
      sel = $urandom_range(0, 9);
      a = (sel == 0) ? 25'h1000000 : (sel == 1) ? 25'h0FFFFFF : 25'($urandom);
      b = (sel == 0) ? 18'h20000 : (sel == 1) ? 18'h1FFFF : 18'($urandom);
      c = {16'($urandom), 32'($urandom)};
      pcin = {16'($urandom), 32'($urandom)};
      op = 2'($urandom);
      ce_ab = ($urandom_range(0, 9) != 0);
      ce_c  = ($urandom_range(0, 9) != 0);
      ce_m  = ($urandom_range(0, 9) != 0);
      ce_p  = ($urandom_range(0, 9) != 0);
      rst_ab = ($urandom_range(0, 39) == 0);
      rst_c  = ($urandom_range(0, 39) == 0);
      rst_m  = ($urandom_range(0, 39) == 0);
      rst_p  = ($urandom_range(0, 39) == 0);
      tick(1);
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule